// File: doc/BRIEF.md
# Peripheral-Paced Parallel Port Handshake Controller

This block runs one enhanced parallel port transfer between a host I/O bus and an attached peripheral. The peripheral paces the exchange with its BUSY line. When the host opens an I/O cycle to one of the upper port offsets, the controller pulls the host ready line low at once. It waits until BUSY has been low long enough, then asserts the peripheral strobes. It releases the host when BUSY has been high long enough.

BUSY is brought into the clock domain through a two-flop synchronizer and then qualified by a stability counter. A cycle counter aborts any transfer that the peripheral never completes. The abort frees the host bus and latches a sticky timeout flag, which software clears by writing a one or by leaving the mode. Both the qualification interval and the abort interval are given in nanoseconds and microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `epp_hs_ctrl`

## Requirements
- R1: With the mode enabled, a new host request (rising `io_req`) to offset 3..7 drives `host_rdy` low in the same cycle, combinationally. It stays low until the cycle completes or aborts.
- R2: The write phase (`data_chg_en` high, and `wr_strb_n` low on writes) begins only after the synchronized BUSY has been low for SETTLE_CYC clocks. If that low time was already reached before the request, the phase begins on the first clock edge of the cycle.
- R3: One clock after the write phase begins, `addr_strb_n` goes low for offset 3, or `data_strb_n` goes low for offsets 4..7. Only one of the two is low. `wr_strb_n` is low only on writes (`io_write`=1).
- R4: After BUSY has been high for SETTLE_CYC clocks during the strobe phase, `host_rdy` goes high and every strobe is released in the same cycle.
- R5: If the cycle has not completed TMO_CYC clocks after it started, it aborts. `host_rdy` rises, all strobes are released and `data_chg_en` is deasserted together.
- R6: An abort sets `tmo_flag`. The flag stays set across later cycles until it is cleared.
- R7: A control write (`ctl_wr`=1) with `ctl_wbit0`=1 clears `tmo_flag`. A control write with `ctl_wbit0`=0 leaves it unchanged.
- R8: While `mode_en` is low, `tmo_flag` reads 0 and no request starts a handshake.
- R9: Requests to offsets 0..2 start no handshake. `host_rdy` stays high and all strobes stay inactive.
- R10: After an abort, changes on BUSY leave every output unchanged until a new request starts.
- R11: A BUSY low pulse shorter than SETTLE_CYC clocks does not open the write phase.
- R12: During and after reset, `host_rdy`=1, all strobes are high, `data_chg_en`=0 and `tmo_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | Host I/O cycle active; a rising edge starts a request |
| io_addr | input | 3 | Port offset of the host cycle |
| io_write | input | 1 | 1 = host write, 0 = host read |
| busy | input | 1 | Peripheral BUSY, asynchronous |
| mode_en | input | 1 | Enhanced port mode enable |
| ctl_wr | input | 1 | Host write to the control register |
| ctl_wbit0 | input | 1 | Bit 0 of the control write data |
| host_rdy | output | 1 | Host ready; low holds the host cycle |
| wr_strb_n | output | 1 | Peripheral write strobe, active low |
| addr_strb_n | output | 1 | Address strobe, active low |
| data_strb_n | output | 1 | Data strobe, active low |
| data_chg_en | output | 1 | Output data may change |
| tmo_flag | output | 1 | Sticky timeout status (control bit 0) |

## Verification
A wrong state in the sequencer shows up at the ports within one clock. A strobe can fall before BUSY has settled, the wrong strobe can fall for the offset, or `host_rdy` can stay low after BUSY has been high for the settle time plus three clocks. A faulty stability counter moves the strobe edge or the release edge away from the window of SETTLE_CYC+3 to SETTLE_CYC+4 clocks. A faulty abort counter moves the forced release away from TMO_CYC clocks, or leaves `tmo_flag` unset, and the bench observes this at the point the abort should have happened.

// File: rtl/epp_hs_pkg.sv
package epp_hs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAL = 2'd1,
    ST_STRB = 2'd2,
    ST_XFER = 2'd3
  } hs_state_e;

  // Round a duration up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/epp_busy_filter.sv
module epp_busy_filter #(
  parameter int unsigned SETTLE_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic low_ok_o,
  output logic high_ok_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(SETTLE_CYC);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (sync1_q != sync2_q)  cnt_nxt = '0;
    else if (cnt_q == SAT)   cnt_nxt = cnt_q;
    else                     cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= busy_i;
      sync2_q <= sync1_q;
      cnt_q   <= cnt_nxt;
    end
  end

  assign low_ok_o  = !sync2_q && (cnt_q == SAT);
  assign high_ok_o =  sync2_q && (cnt_q == SAT);

  // A qualified low level must have been low on the previous cycle too.
  assert_low_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    low_ok_o |-> !$past(sync2_q));
  assert_high_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    high_ok_o |-> $past(sync2_q));

endmodule

// File: rtl/epp_tmo_timer.sv
module epp_tmo_timer #(
  parameter int unsigned TMO_CYC = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;

  assign cnt_en  = run_i && (cnt_q != LAST);
  assign cnt_nxt = run_i ? cnt_q + 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (cnt_en || !run_i)  cnt_q <= cnt_nxt;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // The first cycle of a run can never be the expiry cycle.
  assert_no_early_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !$past(run_i)) |-> !expire_o);

endmodule

// File: rtl/epp_hs_fsm.sv
module epp_hs_fsm
  import epp_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_req,
  input  logic [2:0] io_addr,
  input  logic       io_write,
  input  logic       mode_en,
  input  logic       low_ok,
  input  logic       high_ok,
  input  logic       tmo_exp,
  output logic       active_o,
  output logic       tmo_hit_o,
  output logic       host_rdy,
  output logic       wr_strb_n,
  output logic       addr_strb_n,
  output logic       data_strb_n,
  output logic       data_chg_en
);
  hs_state_e st_q, st_nxt;
  logic      req_q;
  logic      is_addr_q, is_wr_q;
  logic      start_hit, done_hit;

  assign start_hit = (st_q == ST_IDLE) && mode_en && io_req && !req_q
                     && (io_addr >= 3'd3);
  assign done_hit  = (st_q == ST_XFER) && high_ok;
  assign tmo_hit_o = (st_q != ST_IDLE) && tmo_exp && !done_hit && mode_en;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE: if (start_hit) st_nxt = low_ok ? ST_STRB : ST_QUAL;
      ST_QUAL: if (low_ok)    st_nxt = ST_STRB;
      ST_STRB:                st_nxt = ST_XFER;
      ST_XFER: if (high_ok)   st_nxt = ST_IDLE;
      default:                st_nxt = ST_IDLE;
    endcase
    if (st_q != ST_IDLE && (tmo_exp || !mode_en)) st_nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      req_q     <= 1'b0;
      is_addr_q <= 1'b0;
      is_wr_q   <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      req_q <= io_req;
      if (start_hit) begin
        is_addr_q <= (io_addr == 3'd3);
        is_wr_q   <= io_write;
      end
    end
  end

  logic phase_on;
  assign phase_on    = (st_q == ST_STRB) || (st_q == ST_XFER);
  assign active_o    = (st_q != ST_IDLE);
  assign host_rdy    = !(active_o || start_hit);
  assign data_chg_en = phase_on && is_wr_q;
  assign wr_strb_n   = !(phase_on && is_wr_q);
  assign addr_strb_n = !((st_q == ST_XFER) && is_addr_q);
  assign data_strb_n = !((st_q == ST_XFER) && !is_addr_q);

  assert_phase_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_on && !$past(phase_on)) |-> $past(low_ok));
  assert_wait_when_unsettled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit && !low_ok && !tmo_exp) |=> (st_q == ST_QUAL));
  assert_release_on_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> (host_rdy && addr_strb_n && data_strb_n && wr_strb_n));
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!addr_strb_n && !data_strb_n));
  assert_abort_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit_o |=> (st_q == ST_IDLE));

endmodule

// File: rtl/epp_hs_ctrl.sv
module epp_hs_ctrl
  import epp_hs_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned SETTLE_NS  = 60,
  parameter int unsigned TIMEOUT_US = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_req,
  input  logic [2:0] io_addr,
  input  logic       io_write,
  input  logic       busy,
  input  logic       mode_en,
  input  logic       ctl_wr,
  input  logic       ctl_wbit0,
  output logic       host_rdy,
  output logic       wr_strb_n,
  output logic       addr_strb_n,
  output logic       data_strb_n,
  output logic       data_chg_en,
  output logic       tmo_flag
);
  localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_MHZ);
  localparam int unsigned TMO_CYC    = TIMEOUT_US * CLK_MHZ;

  logic low_ok, high_ok, tmo_exp, active, tmo_hit;
  logic flag_q, flag_nxt;

  epp_busy_filter #(.SETTLE_CYC(SETTLE_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .busy_i(busy),
    .low_ok_o(low_ok), .high_ok_o(high_ok)
  );

  epp_tmo_timer #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run_i(active), .expire_o(tmo_exp)
  );

  epp_hs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr(io_addr),
    .io_write(io_write), .mode_en(mode_en), .low_ok(low_ok),
    .high_ok(high_ok), .tmo_exp(tmo_exp), .active_o(active),
    .tmo_hit_o(tmo_hit), .host_rdy(host_rdy), .wr_strb_n(wr_strb_n),
    .addr_strb_n(addr_strb_n), .data_strb_n(data_strb_n),
    .data_chg_en(data_chg_en)
  );

  // Priority: mode disable clears, then a timeout sets, then write-one clears.
  always_comb begin
    flag_nxt = flag_q;
    if (!mode_en)                flag_nxt = 1'b0;
    else if (tmo_hit)            flag_nxt = 1'b1;
    else if (ctl_wr && ctl_wbit0) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt;
  end

  assign tmo_flag = flag_q;

  assert_flag_from_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(active));
  assert_flag_off_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !tmo_flag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmo_flag) && mode_en && !$past(ctl_wr && ctl_wbit0) && $past(mode_en)) |-> tmo_flag);

endmodule

// File: tb/sim_epp_hs_ctrl.sv
`timescale 1ns/1ps
module sim_epp_hs_ctrl;
  localparam int S = 15;   // 60 ns at 250 MHz
  localparam int T = 500;  // 2 us at 250 MHz

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_req = 0, io_write = 0, busy = 1, mode_en = 1, ctl_wr = 0, ctl_wbit0 = 0;
  logic [2:0] io_addr = '0;
  logic host_rdy, wr_strb_n, addr_strb_n, data_strb_n, data_chg_en, tmo_flag;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  epp_hs_ctrl #(.CLK_MHZ(250), .SETTLE_NS(60), .TIMEOUT_US(2)) u0 (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_addr(io_addr),
    .io_write(io_write), .busy(busy), .mode_en(mode_en), .ctl_wr(ctl_wr),
    .ctl_wbit0(ctl_wbit0), .host_rdy(host_rdy), .wr_strb_n(wr_strb_n),
    .addr_strb_n(addr_strb_n), .data_strb_n(data_strb_n),
    .data_chg_en(data_chg_en), .tmo_flag(tmo_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {host_rdy, wr_strb_n, addr_strb_n, data_strb_n, data_chg_en};
  endfunction
  localparam int IDLE_OUTS = 5'b11110;

  // Vector: {addr[2:0], write, busy_pre_low, abort, hold[7:0]}
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {3'd3, 1'b1, 1'b1, 1'b0, 8'd5},
    {3'd4, 1'b0, 1'b1, 1'b0, 8'd0},
    {3'd7, 1'b1, 1'b0, 1'b0, 8'd10},
    {3'd5, 1'b0, 1'b0, 1'b0, 8'd3},
    {3'd6, 1'b1, 1'b1, 1'b1, 8'd0},
    {3'd3, 1'b0, 1'b0, 1'b1, 8'd0},
    {3'd1, 1'b1, 1'b1, 1'b0, 8'd0},
    {3'd0, 1'b0, 1'b0, 1'b0, 8'd0},
    {3'd2, 1'b1, 1'b0, 1'b0, 8'd0}
  };

  task automatic ctl_clear();
    @(negedge clk); ctl_wr = 1; ctl_wbit0 = 1;
    @(negedge clk); ctl_wr = 0; ctl_wbit0 = 0;
  endtask

  task automatic run_vec(input logic [13:0] v);
    logic [2:0] a; bit w, pre, ab, seen, done, bhi; int hold, age, ts;
    a = v[13:11]; w = v[10]; pre = v[9]; ab = v[8]; hold = int'(v[7:0]);
    @(negedge clk); busy = pre ? 1'b0 : 1'b1;
    repeat (S + 10) @(negedge clk);
    age = S + 10; bhi = !pre;
    io_addr = a; io_write = w; io_req = 1;
    if (!pre) begin busy = 0; bhi = 0; age = 0; end
    #1;
    if (a < 3) begin
      chk(host_rdy == 1, "R9 host_rdy on low offset", host_rdy, 1);
      for (int k = 0; k < 2 * S; k++) begin
        @(negedge clk);
        if (outs() != IDLE_OUTS) chk(0, "R9 outputs idle on low offset", outs(), IDLE_OUTS);
      end
      chk(outs() == IDLE_OUTS, "R9 no handshake", outs(), IDLE_OUTS);
      io_req = 0;
      return;
    end
    chk(host_rdy == 0, "R1 host_rdy low at request", host_rdy, 0);
    seen = 0; done = 0; ts = 0;
    for (int n = 1; n <= T + 20 && !done; n++) begin
      @(negedge clk); age++;
      if (!seen && (data_chg_en || !addr_strb_n || !data_strb_n)) begin
        seen = 1; ts = n;
        chk(age >= S, "R2 phase after settled low", age, S);
        chk(n <= (pre ? 2 : S + 4), "R2 no extra wait", n, pre ? 2 : S + 4);
        chk(host_rdy == 0, "R1 host_rdy held low", host_rdy, 0);
        if (w) chk(addr_strb_n && data_strb_n && !wr_strb_n, "R3 write strobe first",
                   {addr_strb_n, data_strb_n, wr_strb_n}, 3'b110);
      end
      if (seen && n == ts + (w ? 1 : 0)) begin
        chk(addr_strb_n == (a != 3) && data_strb_n == (a == 3) && wr_strb_n == !w,
            "R3 strobe by offset", {addr_strb_n, data_strb_n, wr_strb_n},
            {a != 3'd3, a == 3'd3, !w});
      end
      if (host_rdy) begin
        done = 1;
        chk(outs() == IDLE_OUTS, ab ? "R5 abort releases all" : "R4 release together",
            outs(), IDLE_OUTS);
        if (ab) begin
          chk(n >= T - 2 && n <= T + 3, "R5 abort timing", n, T);
          chk(tmo_flag == 1, "R6 flag set on abort", tmo_flag, 1);
        end else begin
          chk(bhi && age >= S && age <= S + 4, "R4 release after settled high", age, S + 3);
          chk(tmo_flag == 0, "R6 no flag on completion", tmo_flag, 0);
        end
      end
      if (!ab && seen && !bhi && n >= ts + hold + 1) begin busy = 1; bhi = 1; age = 0; end
    end
    if (!done) chk(0, "R4/R5 cycle never ended", 0, 1);
    if (ab) begin
      busy = 1;
      for (int k = 0; k < 3 * S; k++) begin
        @(negedge clk);
        if (k == S) busy = 0;
        if (outs() != IDLE_OUTS) chk(0, "R10 busy ignored after abort", outs(), IDLE_OUTS);
      end
      chk(outs() == IDLE_OUTS, "R10 idle after abort", outs(), IDLE_OUTS);
      chk(tmo_flag == 1, "R6 flag sticky", tmo_flag, 1);
    end
    io_req = 0;
    @(negedge clk);
    ctl_clear();
  endtask

  initial begin
    #1;
    chk(outs() == IDLE_OUTS && tmo_flag == 0, "R12 outputs in reset", outs(), IDLE_OUTS);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(outs() == IDLE_OUTS && tmo_flag == 0, "R12 outputs after reset", outs(), IDLE_OUTS);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R11: short low pulse on BUSY must not open the write phase
    @(negedge clk); busy = 1; repeat (S + 5) @(negedge clk);
    io_addr = 3'd4; io_write = 1; io_req = 1;
    repeat (3) @(negedge clk);
    busy = 0; repeat (S - 6) @(negedge clk); busy = 1;
    for (int k = 0; k < 2 * S; k++) begin
      @(negedge clk);
      if (data_chg_en || !data_strb_n) chk(0, "R11 short pulse ignored", data_chg_en, 0);
    end
    chk(!data_chg_en && data_strb_n && !host_rdy, "R11 still waiting", data_chg_en, 0);
    busy = 0; repeat (S + 6) @(negedge clk);
    chk(!data_strb_n, "R11 long low qualifies", data_strb_n, 0);
    busy = 1; repeat (S + 5) @(negedge clk);
    chk(host_rdy == 1, "R4 completes after glitch test", host_rdy, 1);
    io_req = 0; @(negedge clk);

    // R7: write of zero keeps flag, write of one clears it
    busy = 1; io_addr = 3'd5; io_write = 0; io_req = 1;
    repeat (T + 5) @(negedge clk);
    io_req = 0;
    chk(tmo_flag == 1, "R6 flag set for R7 test", tmo_flag, 1);
    @(negedge clk); ctl_wr = 1; ctl_wbit0 = 0;
    @(negedge clk); ctl_wr = 0;
    @(negedge clk);
    chk(tmo_flag == 1, "R7 write 0 no effect", tmo_flag, 1);
    ctl_clear(); @(negedge clk);
    chk(tmo_flag == 0, "R7 write 1 clears", tmo_flag, 0);

    // R8: mode disable clears flag and blocks requests
    io_req = 1; repeat (T + 5) @(negedge clk); io_req = 0;
    chk(tmo_flag == 1, "R6 flag set for R8 test", tmo_flag, 1);
    @(negedge clk); mode_en = 0; @(negedge clk);
    chk(tmo_flag == 0, "R8 disable clears flag", tmo_flag, 0);
    busy = 0; io_addr = 3'd4; io_req = 1; #1;
    chk(host_rdy == 1, "R8 no start while disabled", host_rdy, 1);
    repeat (S + 6) @(negedge clk);
    chk(outs() == IDLE_OUTS, "R8 no handshake while disabled", outs(), IDLE_OUTS);
    io_req = 0; mode_en = 1; @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule